// File: doc/BRIEF.md
# 72-bit SEC-DED Memory Word Codec

This block protects a 64-bit memory word with eight check bits. Its write side takes the data that is about to be stored and produces the check byte that goes with it. Its read side takes a stored 72-bit word and returns the data. Any single flipped bit is repaired, whether it sits in the data or in the check byte. Patterns with more flipped bits that cannot be resolved are reported and not changed. The read side also reports the 8-bit syndrome and the position of the repaired bit.

The code is defined by a fixed parity-check matrix with odd-weight columns. Every data bit has an explicit column, and each check bit has a one-hot column. Error injection needs no separate port. When the keep input is set on a write, the check-byte output repeats the check byte already stored rather than the new one. The next read of that word then shows the mismatch. Both sides are registered, so each result appears one clock after its inputs.

Top module: `ecc72_codec`

## Requirements
- R1: Codeword layout: bits 0..63 of the 72-bit word are data and bits 64..71 are check bits. Check bit at position 64+k has the one-hot column 8'h80 >> k, so position 64 owns syndrome bit 7 and position 71 owns syndrome bit 0.
- R2: The data-bit columns for bits 0 up to 63, in hex, are F4 F1 EC EA E9 E6 E5 E3 DC DA D9 D6 D5 D3 CE CB B5 B0 AD AB A8 A7 A4 A2 9D 9B 98 97 94 92 8F 8A 75 70 6D 6B 68 67 64 62 5E 5B 58 57 54 52 4F 4A 34 31 2C 2A 29 26 25 23 1C 1A 19 16 15 13 0E 0B. The encoder sets each check bit so that the XOR of the columns of all set bits in the 72-bit word is zero.
- R3: When enc_keep is high, enc_chk takes enc_prev_chk instead of the computed check byte.
- R4: A read word whose syndrome is zero returns its data unchanged, with neither strobe set and an index of 0.
- R5: A read word with exactly one flipped data bit returns the repaired data, sets dec_corr, and gives that bit's position (0..63) on dec_idx.
- R6: A read word with exactly one flipped check bit returns the data unchanged, sets dec_corr, and gives position 64+k on dec_idx.
- R7: A nonzero syndrome that matches no column, including every even-weight syndrome, sets dec_uncorr only. The data passes through unmodified and dec_idx is 0.
- R8: dec_syn is the XOR of the columns of all set bits in the read word.
- R9: Read results and dec_valid appear one clock after dec_in_valid. Both strobes are low whenever dec_valid is low.
- R10: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data | input | 64 | Data about to be written |
| enc_keep | input | 1 | Keep the stored check byte (error injection) |
| enc_prev_chk | input | 8 | Check byte currently stored at the target |
| enc_chk | output | 8 | Check byte to store, positions 64..71 |
| dec_in_valid | input | 1 | Read word is present |
| dec_word | input | 72 | Stored 72-bit word being read |
| dec_valid | output | 1 | Read result valid |
| dec_data | output | 64 | Data after correction |
| dec_syn | output | 8 | Syndrome |
| dec_idx | output | 7 | Position of the repaired bit |
| dec_corr | output | 1 | Single-bit error repaired |
| dec_uncorr | output | 1 | Uncorrectable error |

## Verification
Both sides have exactly one register stage. enc_chk therefore reflects the inputs present at the previous rising edge, and every read result reflects the dec_word and dec_in_valid present at that edge. The bench model is updated at each rising edge from the inputs driven at the prior falling edge. It compares all outputs 5 ns after that same edge, so every cycle gets one comparison aligned to the single register stage. The test cases cover a flip at every one of the 72 positions, double and quad flips, and words built with the keep input.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int IDX_W  = $clog2(WORD_W);

  localparam logic [CHK_W-1:0] DATA_COL [DATA_W] = '{
    8'hF4, 8'hF1, 8'hEC, 8'hEA, 8'hE9, 8'hE6, 8'hE5, 8'hE3,
    8'hDC, 8'hDA, 8'hD9, 8'hD6, 8'hD5, 8'hD3, 8'hCE, 8'hCB,
    8'hB5, 8'hB0, 8'hAD, 8'hAB, 8'hA8, 8'hA7, 8'hA4, 8'hA2,
    8'h9D, 8'h9B, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8F, 8'h8A,
    8'h75, 8'h70, 8'h6D, 8'h6B, 8'h68, 8'h67, 8'h64, 8'h62,
    8'h5E, 8'h5B, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4F, 8'h4A,
    8'h34, 8'h31, 8'h2C, 8'h2A, 8'h29, 8'h26, 8'h25, 8'h23,
    8'h1C, 8'h1A, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0E, 8'h0B
  };

  // Column of any codeword position; check columns are one-hot, MSB first.
  function automatic logic [CHK_W-1:0] col_of(input int pos);
    logic [CHK_W-1:0] c;
    if (pos < DATA_W) c = DATA_COL[pos];
    else              c = (CHK_W)'(1 << (CHK_W - 1 - (pos - DATA_W)));
    return c;
  endfunction

  // Data bits that feed syndrome row r.
  function automatic logic [DATA_W-1:0] row_mask(input int r);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = DATA_COL[i][r];
    return m;
  endfunction
endpackage

// File: rtl/ecc72_checkgen.sv
module ecc72_checkgen
  import ecc72_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk    // storage order: chk[k] is position 64+k
);
  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(r);
    assign chk[CHK_W-1-r] = ^(data & MASK);
  end
endmodule

// File: rtl/ecc72_locate.sv
module ecc72_locate
  import ecc72_pkg::*;
(
  input  logic [CHK_W-1:0]  syn,
  output logic [WORD_W-1:0] flip,
  output logic [IDX_W-1:0]  idx,
  output logic              corr,
  output logic              uncorr
);
  for (genvar p = 0; p < WORD_W; p++) begin : g_cmp
    localparam logic [CHK_W-1:0] COL = col_of(p);
    assign flip[p] = (syn == COL);
  end

  always_comb begin
    idx = '0;
    for (int p = 0; p < WORD_W; p++)
      if (flip[p]) idx = idx | (IDX_W)'(p);
  end

  assign corr   = |flip;
  assign uncorr = (syn != '0) && !corr;
endmodule

// File: rtl/ecc72_codec.sv
module ecc72_codec
  import ecc72_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] enc_data,
  input  logic              enc_keep,
  input  logic [CHK_W-1:0]  enc_prev_chk,
  output logic [CHK_W-1:0]  enc_chk,
  input  logic              dec_in_valid,
  input  logic [WORD_W-1:0] dec_word,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data,
  output logic [CHK_W-1:0]  dec_syn,
  output logic [IDX_W-1:0]  dec_idx,
  output logic              dec_corr,
  output logic              dec_uncorr
);
  // ---------------- write side ----------------
  logic [CHK_W-1:0] enc_calc;

  ecc72_checkgen u_enc_gen (.data(enc_data), .chk(enc_calc));

  always_ff @(posedge clk) begin
    if (rst) enc_chk <= '0;
    else     enc_chk <= enc_keep ? enc_prev_chk : enc_calc;
  end

  // ---------------- read side ----------------
  logic [CHK_W-1:0]  rd_calc, rd_diff, rd_syn;
  logic [WORD_W-1:0] rd_flip, rd_fixed;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_corr, rd_uncorr;

  ecc72_checkgen u_dec_gen (.data(dec_word[DATA_W-1:0]), .chk(rd_calc));

  assign rd_diff = rd_calc ^ dec_word[WORD_W-1:DATA_W];
  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign rd_syn[CHK_W-1-k] = rd_diff[k];
  end

  ecc72_locate u_loc (
    .syn(rd_syn), .flip(rd_flip), .idx(rd_idx),
    .corr(rd_corr), .uncorr(rd_uncorr)
  );

  assign rd_fixed = dec_word ^ rd_flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_data   <= '0;
      dec_syn    <= '0;
      dec_idx    <= '0;
      dec_corr   <= 1'b0;
      dec_uncorr <= 1'b0;
    end else begin
      dec_valid  <= dec_in_valid;
      dec_data   <= rd_fixed[DATA_W-1:0];
      dec_syn    <= rd_syn;
      dec_idx    <= rd_idx;
      dec_corr   <= dec_in_valid && rd_corr;
      dec_uncorr <= dec_in_valid && rd_uncorr;
    end
  end

  // ---------------- assertions ----------------
  AST_BYPASS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    enc_keep |=> enc_chk == $past(enc_prev_chk)); // R3
  AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dec_syn == '0) |-> !dec_corr && !dec_uncorr); // R4
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dec_corr && dec_uncorr)); // R7
  AST_EVEN_UNCORR: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_syn != '0 && !(^dec_syn)) |-> dec_uncorr); // R7
  AST_UNCORR_IDX: assert property (@(posedge clk) disable iff (rst)
    dec_uncorr |-> dec_idx == '0); // R7
  AST_UNCORR_PASS: assert property (@(posedge clk) disable iff (rst)
    dec_uncorr |-> dec_data == $past(dec_word[DATA_W-1:0])); // R7
  AST_STROBE_VALID: assert property (@(posedge clk) disable iff (rst)
    (dec_corr || dec_uncorr) |-> dec_valid); // R9
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    dec_in_valid |=> dec_valid); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !dec_valid && !dec_corr && !dec_uncorr && enc_chk == '0); // R10
endmodule

// File: tb/ecc72_codec_test.sv
module ecc72_codec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] enc_data = '0;
  logic        enc_keep = 1'b0;
  logic [7:0]  enc_prev_chk = '0;
  logic [7:0]  enc_chk;
  logic        dec_in_valid = 1'b0;
  logic [71:0] dec_word = '0;
  logic        dec_valid;
  logic [63:0] dec_data;
  logic [7:0]  dec_syn;
  logic [6:0]  dec_idx;
  logic        dec_corr, dec_uncorr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  ecc72_codec uut (
    .clk(clk), .rst(rst), .enc_data(enc_data), .enc_keep(enc_keep),
    .enc_prev_chk(enc_prev_chk), .enc_chk(enc_chk),
    .dec_in_valid(dec_in_valid), .dec_word(dec_word), .dec_valid(dec_valid),
    .dec_data(dec_data), .dec_syn(dec_syn), .dec_idx(dec_idx),
    .dec_corr(dec_corr), .dec_uncorr(dec_uncorr)
  );

  always #10 clk = ~clk;   // 50 MHz

  // Columns from R2, stored the way the requirement reads them.
  byte unsigned cols [64] = '{
    8'hF4, 8'hF1, 8'hEC, 8'hEA, 8'hE9, 8'hE6, 8'hE5, 8'hE3,
    8'hDC, 8'hDA, 8'hD9, 8'hD6, 8'hD5, 8'hD3, 8'hCE, 8'hCB,
    8'hB5, 8'hB0, 8'hAD, 8'hAB, 8'hA8, 8'hA7, 8'hA4, 8'hA2,
    8'h9D, 8'h9B, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8F, 8'h8A,
    8'h75, 8'h70, 8'h6D, 8'h6B, 8'h68, 8'h67, 8'h64, 8'h62,
    8'h5E, 8'h5B, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4F, 8'h4A,
    8'h34, 8'h31, 8'h2C, 8'h2A, 8'h29, 8'h26, 8'h25, 8'h23,
    8'h1C, 8'h1A, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0E, 8'h0B
  };

  function automatic logic [7:0] pos_col(int p);   // R1
    return (p < 64) ? cols[p] : (8'h80 >> (p - 64));
  endfunction

  function automatic logic [7:0] word_syn(logic [71:0] w);   // R8
    logic [7:0] s = '0;
    for (int p = 0; p < 72; p++) if (w[p]) s ^= pos_col(p);
    return s;
  endfunction

  // Check byte that makes the syndrome zero (R2).
  function automatic logic [7:0] make_chk(logic [63:0] d);
    logic [7:0] s = word_syn({8'h00, d});
    logic [7:0] c;
    for (int k = 0; k < 8; k++) c[k] = s[7-k];
    return c;
  endfunction

  // Reference model, updated at every rising edge.
  logic [7:0]  m_chk = '0, m_syn = '0;
  logic [63:0] m_data = '0;
  logic [6:0]  m_idx = '0;
  logic        m_valid = 0, m_corr = 0, m_unc = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_chk = '0; m_syn = '0; m_data = '0; m_idx = '0;
      m_valid = 0; m_corr = 0; m_unc = 0;
    end else begin
      int hit;
      logic [71:0] fixed;
      m_chk   = enc_keep ? enc_prev_chk : make_chk(enc_data);
      m_valid = dec_in_valid;
      m_syn   = word_syn(dec_word);
      hit = -1;
      for (int p = 0; p < 72; p++) if (m_syn != 0 && pos_col(p) == m_syn) hit = p;
      fixed   = dec_word;
      if (hit >= 0) fixed[hit] = ~fixed[hit];
      m_data  = fixed[63:0];
      m_idx   = (hit >= 0) ? 7'(hit) : 7'd0;
      m_corr  = dec_in_valid && hit >= 0;
      m_unc   = dec_in_valid && m_syn != 0 && hit < 0;
    end
    #5;
    cmp(64'(enc_chk), 64'(m_chk), "R2/R3 enc_chk");
    cmp(64'(dec_valid), 64'(m_valid), "R9/R10 dec_valid");
    cmp(dec_data, m_data, "R4/R5/R6/R7 dec_data");
    cmp(64'(dec_syn), 64'(m_syn), "R8 dec_syn");
    cmp(64'(dec_idx), 64'(m_idx), "R5/R6 dec_idx");
    cmp(64'(dec_corr), 64'(m_corr), "R5/R6 dec_corr");
    cmp(64'(dec_uncorr), 64'(m_unc), "R7 dec_uncorr");
  end

  task automatic cmp(logic [63:0] act, logic [63:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic rd(logic [71:0] w, bit v = 1);
    @(negedge clk);
    dec_word = w; dec_in_valid = v;
  endtask

  task automatic wr(logic [63:0] d, bit keep, logic [7:0] prev);
    @(negedge clk);
    enc_data = d; enc_keep = keep; enc_prev_chk = prev;
  endtask

  initial begin
    logic [63:0] d;
    logic [71:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;                          // R10 checked during reset cycles
    // R4: clean words
    for (int n = 0; n < 6; n++) begin
      d = {$urandom, $urandom};
      wr(d, 0, 8'h00);
      rd({make_chk(d), d});
    end
    // R5, R6: single flip at every position, two patterns
    for (int t = 0; t < 2; t++) begin
      d = (t == 0) ? 64'h0101_0101_0101_0101 : {$urandom, $urandom};
      for (int p = 0; p < 72; p++) begin
        w = {make_chk(d), d};
        w[p] = ~w[p];
        rd(w);
      end
    end
    // R7: double flips (always even-weight syndrome)
    for (int n = 0; n < 20; n++) begin
      int a = $urandom_range(0, 71);
      int b = (a + 1 + $urandom_range(0, 70)) % 72;
      d = {$urandom, $urandom};
      w = {make_chk(d), d};
      w[a] = ~w[a]; w[b] = ~w[b];
      rd(w);
    end
    // R7: top nibble of a 32-bit lane flipped from 0 to F
    d = 64'h0101_0101_0101_0101;
    rd({make_chk(d), d ^ 64'h0000_0000_F000_0000});
    rd({make_chk(d), d ^ 64'hF000_0000_0000_0000});
    // R9: idle cycles with garbage on the bus
    rd({8'hFF, 64'hDEAD_BEEF_0000_0003}, 0);
    rd(72'h0, 0);
    // R3: keep the old check byte, then read the mismatched word
    d = 64'h0101_0101_0101_0101;
    wr(d, 0, 8'h00);
    wr(d ^ 64'h0000_0000_1000_0000, 1, make_chk(d));
    rd({make_chk(d), d ^ 64'h0000_0000_1000_0000});
    wr(d ^ 64'h0000_0000_F000_0000, 1, make_chk(d));
    rd({make_chk(d), d ^ 64'h0000_0000_F000_0000});
    wr(64'h0, 1, 8'hA5);
    rd(72'h0, 0);
    // R10: reset mid-run
    rd({8'h00, 64'h1}, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(72'h0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule